// File: doc/BRIEF.md
# Outer-Level Occupancy Servo

This block watches a stream of two-bit sample codes from a three-level sampler, presented on several parallel lanes each clock. For each lane it keeps one counter of positive-outer codes and one counter of negative-outer codes. A separate counter tracks the enabled clocks. When the clock counter's top bit toggles, a measurement window has closed. The summed outer counts of each polarity are then compared against a target share of the samples in that window.

Each comparison steers one threshold control word per polarity by a single step. A count above target raises the word, which narrows the outer levels. A count below target lowers it. Inside a deadband the word holds. The words would feed the threshold DACs. The default target keeps the total outer occupancy near 54%, which is the best operating point for a three-level correlator.

The sample counters restart at every update, so each window is measured independently. Only the top bit of each counter is brought out.

Top module: `outer_level_servo`

## Requirements
- R1: With `rst` high at a clock edge, all counters are cleared. After that edge every counter top bit reads 0, both threshold words equal THR_INIT (default 128), and `win_done`, `pos_in_band` and `neg_in_band` read 0.
- R2: Lane l uses `codes[2l+1:2l]`. Code 01 is positive-outer and increments that lane's positive counter. Code 10 is negative-outer and increments that lane's negative counter. Codes 00 and 11 count nowhere. `pos_msb[l]` and `neg_msb[l]` show bit 7 of each 8-bit counter, so after a full window in which a lane saw 128 outer codes of one polarity, that bit reads 1.
- R3: The clock counter advances once per enabled clock, and `clk_msb` shows its bit 7. A window is 128 enabled clocks (512 samples per polarity with 4 lanes), and `clk_msb` toggles once per window.
- R4: While `en` is low, no sample counter and no clock counter advances, whatever the codes are.
- R5: One clock after the window's last enabled clock, each polarity's summed window count N is compared with the target 138 and the deadband 4. If N > 142 the word rises by 1. If N < 134 it falls by 1. Otherwise it holds.
- R6: A threshold word never wraps. It stays at 255 when a rise is due, and at 0 when a fall is due.
- R7: `cnt_clr` high at an edge clears every sample counter and the clock counter, so the top bits read 0 after that edge. It suppresses any update pending at that edge and leaves both threshold words unchanged.
- R8: `win_done` is high for exactly the one cycle in which newly updated words first appear. `pos_in_band` and `neg_in_band` then show whether that polarity's last comparison fell inside the deadband.
- R9: The sample counters restart at each update, so each window's decision depends only on the samples inside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| en | input | 1 | Count enable for samples and clocks |
| codes | input | 2*LANES | Two-bit sample code per lane |
| pos_msb | output | LANES | Bit 7 of each positive-outer lane counter |
| neg_msb | output | LANES | Bit 7 of each negative-outer lane counter |
| clk_msb | output | 1 | Bit 7 of the clock counter |
| thr_pos | output | THR_W | Positive threshold control word |
| thr_neg | output | THR_W | Negative threshold control word |
| win_done | output | 1 | One-cycle pulse when the words have been updated |
| pos_in_band | output | 1 | Last positive comparison was inside the deadband |
| neg_in_band | output | 1 | Last negative comparison was inside the deadband |

## Verification
The assertions assume that `rst` is held for at least one edge before any input is used. They also assume that `cnt_clr` and `en` are clean synchronous levels, so a single edge of history is always defined after reset. The bench drives every input on the falling edge, asserts reset from time zero, and starts each window from a freshly aligned clock counter. The per-lane code patterns are chosen so that the positive and negative counts in a window never sum to more than the 512 samples that window holds.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    SC_INNER = 2'b00,
    SC_POS   = 2'b01,
    SC_NEG   = 2'b10,
    SC_SPARE = 2'b11
  } samp_code_t;
endpackage

// File: rtl/oc_lane_counter.sv
module oc_lane_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             restart,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (restart) begin
      count <= {{(CNT_W-1){1'b0}}, hit};
    end else if (hit) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/oc_window_timer.sv
module oc_window_timer #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic msb,
  output logic upd
);
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = en && (cnt[CNT_W-2:0] == {(CNT_W-1){1'b1}});
  assign msb  = cnt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      upd <= 1'b0;
    end else begin
      if (en) cnt <= cnt + 1'b1;
      upd <= tick;
    end
  end
endmodule

// File: rtl/oc_servo.sv
module oc_servo #(
  parameter int THR_W    = 8,
  parameter int SUM_W    = 10,
  parameter int THR_INIT = 128,
  parameter int TGT      = 138,
  parameter int DEADBAND = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [SUM_W-1:0] outer_sum,
  output logic [THR_W-1:0] thr,
  output logic             in_band
);
  localparam int HI_I = TGT + DEADBAND;
  localparam int LO_I = (TGT > DEADBAND) ? (TGT - DEADBAND) : 0;
  localparam logic [SUM_W+1:0] HI = (SUM_W+2)'(HI_I);
  localparam logic [SUM_W+1:0] LO = (SUM_W+2)'(LO_I);
  localparam logic [THR_W-1:0] TMAX   = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] INIT_W = THR_W'(THR_INIT);

  logic [SUM_W+1:0] sum_x;
  assign sum_x = {2'b00, outer_sum};

  always_ff @(posedge clk) begin
    if (rst) begin
      thr     <= INIT_W;
      in_band <= 1'b0;
    end else if (upd) begin
      if (sum_x > HI) begin
        if (thr != TMAX) thr <= thr + 1'b1;
        in_band <= 1'b0;
      end else if (sum_x < LO) begin
        if (thr != '0) thr <= thr - 1'b1;
        in_band <= 1'b0;
      end else begin
        in_band <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/outer_level_servo.sv
module outer_level_servo
  import oc_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CNT_W     = 8,
  parameter int THR_W     = 8,
  parameter int THR_INIT  = 128,
  parameter int TARGET_Q8 = 138,
  parameter int DEADBAND  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_clr,
  input  logic               en,
  input  logic [2*LANES-1:0] codes,
  output logic [LANES-1:0]   pos_msb,
  output logic [LANES-1:0]   neg_msb,
  output logic               clk_msb,
  output logic [THR_W-1:0]   thr_pos,
  output logic [THR_W-1:0]   thr_neg,
  output logic               win_done,
  output logic               pos_in_band,
  output logic               neg_in_band
);
  localparam int WIN   = 2 ** (CNT_W - 1);
  localparam int TOTAL = WIN * LANES;
  localparam int SUM_W = CNT_W + $clog2(LANES);
  localparam int TGT   = (TARGET_Q8 * TOTAL) / 512;

  logic             upd_pend;
  logic             upd_go;
  logic [CNT_W-1:0] pcnt [LANES];
  logic [CNT_W-1:0] ncnt [LANES];
  logic [SUM_W-1:0] psum;
  logic [SUM_W-1:0] nsum;

  assign upd_go = upd_pend && !cnt_clr;

  oc_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(en),
    .msb(clk_msb), .upd(upd_pend)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit_p, hit_n;
    assign hit_p = en && (codes[2*l +: 2] == SC_POS);
    assign hit_n = en && (codes[2*l +: 2] == SC_NEG);

    oc_lane_counter #(.CNT_W(CNT_W)) u_pos (
      .clk(clk), .rst(rst), .clr(cnt_clr), .restart(upd_pend),
      .hit(hit_p), .count(pcnt[l])
    );
    oc_lane_counter #(.CNT_W(CNT_W)) u_neg (
      .clk(clk), .rst(rst), .clr(cnt_clr), .restart(upd_pend),
      .hit(hit_n), .count(ncnt[l])
    );
    assign pos_msb[l] = pcnt[l][CNT_W-1];
    assign neg_msb[l] = ncnt[l][CNT_W-1];
  end

  always_comb begin
    psum = '0;
    nsum = '0;
    for (int l = 0; l < LANES; l++) begin
      psum = psum + SUM_W'(pcnt[l]);
      nsum = nsum + SUM_W'(ncnt[l]);
    end
  end

  oc_servo #(
    .THR_W(THR_W), .SUM_W(SUM_W), .THR_INIT(THR_INIT),
    .TGT(TGT), .DEADBAND(DEADBAND)
  ) u_srv_pos (
    .clk(clk), .rst(rst), .upd(upd_go), .outer_sum(psum),
    .thr(thr_pos), .in_band(pos_in_band)
  );

  oc_servo #(
    .THR_W(THR_W), .SUM_W(SUM_W), .THR_INIT(THR_INIT),
    .TGT(TGT), .DEADBAND(DEADBAND)
  ) u_srv_neg (
    .clk(clk), .rst(rst), .upd(upd_go), .outer_sum(nsum),
    .thr(thr_neg), .in_band(neg_in_band)
  );

  always_ff @(posedge clk) begin
    if (rst) win_done <= 1'b0;
    else     win_done <= upd_go;
  end
endmodule

// File: rtl/oc_servo_chk.sv
module oc_servo_chk #(
  parameter int LANES = 4,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             en,
  input logic [LANES-1:0] pos_msb,
  input logic [LANES-1:0] neg_msb,
  input logic             clk_msb,
  input logic [THR_W-1:0] thr_pos,
  input logic [THR_W-1:0] thr_neg,
  input logic             win_done
);
  localparam logic [THR_W-1:0] TMAX = {THR_W{1'b1}};

  assert_pos_moves_on_update_R5: assert property (@(posedge clk) disable iff (rst)
    (thr_pos != $past(thr_pos)) |-> win_done);
  assert_neg_moves_on_update_R5: assert property (@(posedge clk) disable iff (rst)
    (thr_neg != $past(thr_neg)) |-> win_done);
  assert_pos_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (thr_pos == $past(thr_pos)) || (thr_pos == THR_W'($past(thr_pos) + 1'b1)) ||
    (thr_pos == THR_W'($past(thr_pos) - 1'b1)));
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !(($past(thr_pos) == TMAX && thr_pos == '0) || ($past(thr_pos) == '0 && thr_pos == TMAX) ||
      ($past(thr_neg) == TMAX && thr_neg == '0) || ($past(thr_neg) == '0 && thr_neg == TMAX)));
  assert_idle_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_clr) |=> $stable(clk_msb));
  assert_clear_counters_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (clk_msb == 1'b0 && pos_msb == '0 && neg_msb == '0));
  assert_clear_holds_words_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (win_done == 1'b0));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done);
endmodule

bind outer_level_servo oc_servo_chk #(.LANES(LANES), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .en(en),
  .pos_msb(pos_msb), .neg_msb(neg_msb), .clk_msb(clk_msb),
  .thr_pos(thr_pos), .thr_neg(thr_neg), .win_done(win_done)
);

// File: tb/test_outer_level_servo.sv
module test_outer_level_servo;
  localparam int NV = 8;
  localparam int VP  [NV] = '{200, 138, 142, 143,   0, 512, 100, 134};
  localparam int VN  [NV] = '{ 50, 138, 134, 133, 512,   0, 300, 142};
  localparam int VDP [NV] = '{  1,   0,   0,   1,  -1,   1,  -1,   0};
  localparam int VDN [NV] = '{ -1,   0,   0,  -1,   1,  -1,   1,   0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_clr = 1'b0;
  logic       en = 1'b0;
  logic [7:0] codes = '0;
  logic [3:0] pos_msb, neg_msb;
  logic       clk_msb, win_done, pos_in_band, neg_in_band;
  logic [7:0] thr_pos, thr_neg;

  int checks = 0;
  int errors = 0;
  int exp_p = 128;
  int exp_n = 128;
  logic exp_clk = 1'b0;

  always #4 clk = ~clk;

  outer_level_servo i_outer_level_servo (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .en(en), .codes(codes),
    .pos_msb(pos_msb), .neg_msb(neg_msb), .clk_msb(clk_msb),
    .thr_pos(thr_pos), .thr_neg(thr_neg), .win_done(win_done),
    .pos_in_band(pos_in_band), .neg_in_band(neg_in_band)
  );

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dir_of(int n);
    if (n > 142) return 1;
    if (n < 134) return -1;
    return 0;
  endfunction

  function automatic int sat(int v);
    if (v > 255) return 255;
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic logic [3:0] msb_exp(int p, int n, bit neg);
    int cnt [4];
    logic [3:0] r;
    for (int l = 0; l < 4; l++) cnt[l] = 0;
    for (int idx = 0; idx < 512; idx++) begin
      if (neg ? (idx >= 512 - n) : (idx < p)) cnt[idx % 4]++;
    end
    for (int l = 0; l < 4; l++) r[l] = (cnt[l] >= 128);
    return r;
  endfunction

  // One window of 128 enabled cycles; optional burst of disabled outer codes at gap_at
  task automatic run_window(int p, int n, int gap_at, bit check_dirs, int dp, int dn);
    int d_p, d_n;
    for (int i = 0; i < 128; i++) begin
      if (i == gap_at) begin
        for (int g = 0; g < 100; g++) begin
          @(negedge clk);
          en = 1'b0;
          codes = 8'b01010101;
        end
      end
      @(negedge clk);
      en = 1'b1;
      for (int l = 0; l < 4; l++) begin
        int idx = i * 4 + l;
        if (idx < p) codes[2*l +: 2] = 2'b01;
        else if (idx >= 512 - n) codes[2*l +: 2] = 2'b10;
        else codes[2*l +: 2] = (i % 2 == 1) ? 2'b11 : 2'b00;
      end
    end
    @(negedge clk);
    exp_clk = ~exp_clk;
    chk("R2", int'(pos_msb), int'(msb_exp(p, n, 1'b0)), "pos lane msb at window end");
    chk("R2", int'(neg_msb), int'(msb_exp(p, n, 1'b1)), "neg lane msb at window end");
    chk("R3", int'(clk_msb), int'(exp_clk), "clock msb toggles per window");
    en = 1'b0;
    codes = '0;
    @(negedge clk);
    d_p = dir_of(p);
    d_n = dir_of(n);
    if (check_dirs) begin
      chk("R5", d_p, dp, "table pos direction");
      chk("R5", d_n, dn, "table neg direction");
    end
    exp_p = sat(exp_p + d_p);
    exp_n = sat(exp_n + d_n);
    chk("R5", int'(thr_pos), exp_p, "thr_pos after window");
    chk("R5", int'(thr_neg), exp_n, "thr_neg after window");
    chk("R8", int'(win_done), 1, "win_done with new words");
    chk("R8", int'(pos_in_band), (d_p == 0) ? 1 : 0, "pos_in_band");
    chk("R8", int'(neg_in_band), (d_n == 0) ? 1 : 0, "neg_in_band");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(thr_pos), 128, "thr_pos after reset");
    chk("R1", int'(thr_neg), 128, "thr_neg after reset");
    chk("R1", int'({pos_msb, neg_msb, clk_msb}), 0, "counter msbs after reset");
    chk("R1", int'({win_done, pos_in_band, neg_in_band}), 0, "status after reset");

    // Vector table: R2 R3 R5 R8 R9 (windows run back to back, each judged alone)
    for (int v = 0; v < NV; v++) begin
      run_window(VP[v], VN[v], -1, 1'b1, VDP[v], VDN[v]);
    end
    @(negedge clk);
    chk("R8", int'(win_done), 0, "win_done lasts one cycle");

    // R4: disabled outer codes mid-window must not count (would turn down into up)
    run_window(100, 300, 64, 1'b1, -1, 1);

    // R7: full window of positive codes, then clear in the update cycle
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      en = 1'b1;
      codes = 8'b01010101;
    end
    @(negedge clk);
    exp_clk = ~exp_clk;
    chk("R2", int'(pos_msb), 15, "pos msbs set by 128 counts per lane");
    cnt_clr = 1'b1;
    en = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    en = 1'b0;
    codes = '0;
    exp_clk = 1'b0;
    chk("R7", int'(pos_msb), 0, "pos msbs cleared");
    chk("R7", int'(clk_msb), 0, "clock msb cleared");
    chk("R7", int'(thr_pos), exp_p, "thr_pos kept over clear");
    chk("R7", int'(thr_neg), exp_n, "thr_neg kept over clear");
    chk("R7", int'(win_done), 0, "pending update suppressed");
    run_window(138, 138, -1, 1'b1, 0, 0);

    // R6: drive both words into their limits and beyond
    for (int w = 0; w < 130; w++) run_window(512, 0, -1, 1'b0, 0, 0);
    chk("R6", int'(thr_pos), 255, "thr_pos saturated high");
    chk("R6", int'(thr_neg), 0, "thr_neg saturated low");

    // R1: reset in mid-run restores the initial words
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", int'(thr_pos), 128, "thr_pos after second reset");
    chk("R1", int'(thr_neg), 128, "thr_neg after second reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule